// File: doc/BRIEF.md
# Hierarchical DMA Transfer Sequencer

This block sequences one DMA channel through a three-level job: a transaction is made of blocks, and each block is made of fragments of bus beats. Software loads the fragment length, the fragments per block and the blocks per transaction, then pulses `start`. A peripheral then paces the work with `req` strobes. The request mode sets how much one strobe authorizes: one fragment, one block or the whole transaction. The sequencer issues one beat per element on a valid/ready handshake, and the beat address counts up by one from a base.

Each level has its own completion pulse. A sticky interrupt latches whichever completion class the interrupt selector names, and a write-one-to-clear strobe resets it. A start with any zero length is refused, and this raises a configuration-error pulse. In list mode the channel runs like transaction mode. It also reports a list completion when the final transaction ends while the external last-node input is high.

Top module: `hxfer_seq`

## Requirements
- R1: After reset `beat_valid`, `busy` and `irq` are low.
- R2: `start` while idle with all three lengths non-zero sets `busy` and loads `beat_addr` with `cfg_base_addr`. `beat_valid` is high only while `busy`. A `req` while not busy is ignored.
- R3: `start` while idle with any length equal to zero pulses `cfg_err` in that cycle, and `busy` stays low.
- R4: Request mode (`cfg_req_mode`, latched at start): 0 lets one `req` run one fragment, 1 one block, and 2 or 3 the whole transaction. When the authorized unit ends, `beat_valid` drops unless a request is pending.
- R5: `frag_done`, `blk_done` and `txn_done` each pulse for one cycle, in the cycle the last beat of that level is accepted. A block end is also a fragment end, and a transaction end is also a block end.
- R6: Each accepted beat advances `beat_addr` by one. While `beat_valid` is high and `beat_ready` is low, `beat_valid` and `beat_addr` hold.
- R7: A `req` that arrives while a unit is authorized is kept as one pending request. Further requests before it is used are merged into it.
- R8: `list_done` pulses with `txn_done` only when the latched mode is 3 and `last_node` is high.
- R9: `cfg_irq_sel` picks the events that set `irq`: 0 none, 1 fragment, 2 block, 3 block or fragment, 4 transaction, 5 transaction or fragment, 6 transaction or block, 7 list, 8 configuration error. The bit then stays set.
- R10: `irq_clr` clears `irq` on the next edge. If a selected event falls in the same cycle, the set wins.
- R11: On `txn_done`, `busy` drops and any pending request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_frag_len | input | LEN_W | Beats per fragment |
| cfg_frags_per_blk | input | LEN_W | Fragments per block |
| cfg_blks_per_txn | input | LEN_W | Blocks per transaction |
| cfg_req_mode | input | 2 | Work authorized per request |
| cfg_irq_sel | input | 4 | Interrupt event selector |
| cfg_base_addr | input | ADDR_W | First beat address |
| start | input | 1 | Arm a transaction |
| req | input | 1 | Peripheral request strobe |
| last_node | input | 1 | Current transaction is the final list node |
| beat_ready | input | 1 | Bus accepts the beat |
| irq_clr | input | 1 | Write-one-to-clear for `irq` |
| beat_valid | output | 1 | Beat offered |
| beat_addr | output | ADDR_W | Beat address |
| busy | output | 1 | Transaction armed and unfinished |
| frag_done | output | 1 | Fragment completion pulse |
| blk_done | output | 1 | Block completion pulse |
| txn_done | output | 1 | Transaction completion pulse |
| list_done | output | 1 | List completion pulse |
| cfg_err | output | 1 | Rejected-start pulse |
| irq | output | 1 | Sticky interrupt |

## Verification
The interrupt latch can see a clear strobe and a selected completion event in the same cycle. The bench provokes this by raising `irq_clr` exactly in the cycle that the second beat of a fragment is accepted, with a fragment-sensitive selector. It then requires `irq` to be high afterwards. A second overlap happens when requests arrive while the channel already has work authorized. The bench stalls `beat_ready`, sends three strobes during the stall and requires exactly two fragments to follow.

// File: rtl/hxs_pkg.sv
package hxs_pkg;
  typedef enum logic [1:0] {
    RM_FRAG  = 2'd0,
    RM_BLOCK = 2'd1,
    RM_TXN   = 2'd2,
    RM_LIST  = 2'd3
  } req_mode_e;

  typedef enum logic [3:0] {
    IS_NONE      = 4'd0,
    IS_FRAG      = 4'd1,
    IS_BLK       = 4'd2,
    IS_BLK_FRAG  = 4'd3,
    IS_TXN       = 4'd4,
    IS_TXN_FRAG  = 4'd5,
    IS_TXN_BLK   = 4'd6,
    IS_LIST      = 4'd7,
    IS_CFGERR    = 4'd8
  } irq_sel_e;

  localparam int unsigned NUM_LEVELS = 3;
endpackage

// File: rtl/hxs_rst_sync.sv
module hxs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/hxs_level_cnt.sv
module hxs_level_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == limit - W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = '0;
    else if (step) cnt_d = last ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load || step) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hxs_auth.sv
module hxs_auth (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic req,
  input  logic unit_end,
  input  logic txn_end,
  output logic grant
);
  logic grant_q, grant_d, pend_q, pend_d;

  always_comb begin
    grant_d = grant_q;
    pend_d  = pend_q;
    if (!active || txn_end) begin
      grant_d = 1'b0;
      pend_d  = 1'b0;
    end else if (grant_q) begin
      if (unit_end) begin
        grant_d = pend_q | req;
        pend_d  = pend_q & req;
      end else begin
        pend_d  = pend_q | req;
      end
    end else begin
      grant_d = req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      pend_q  <= pend_d;
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/hxs_irq.sv
module hxs_irq
  import hxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] sel,
  input  logic       frag_ev,
  input  logic       blk_ev,
  input  logic       txn_ev,
  input  logic       list_ev,
  input  logic       cerr_ev,
  input  logic       clr,
  output logic       irq
);
  logic hit, irq_q, irq_d;

  always_comb begin
    case (sel)
      IS_FRAG:     hit = frag_ev;
      IS_BLK:      hit = blk_ev;
      IS_BLK_FRAG: hit = blk_ev | frag_ev;
      IS_TXN:      hit = txn_ev;
      IS_TXN_FRAG: hit = txn_ev | frag_ev;
      IS_TXN_BLK:  hit = txn_ev | blk_ev;
      IS_LIST:     hit = list_ev;
      IS_CFGERR:   hit = cerr_ev;
      default:     hit = 1'b0;
    endcase
    irq_d = hit ? 1'b1 : (clr ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/hxfer_seq.sv
module hxfer_seq
  import hxs_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_frag_len,
  input  logic [LEN_W-1:0]  cfg_frags_per_blk,
  input  logic [LEN_W-1:0]  cfg_blks_per_txn,
  input  logic [1:0]        cfg_req_mode,
  input  logic [3:0]        cfg_irq_sel,
  input  logic [ADDR_W-1:0] cfg_base_addr,
  input  logic              start,
  input  logic              req,
  input  logic              last_node,
  input  logic              beat_ready,
  input  logic              irq_clr,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              busy,
  output logic              frag_done,
  output logic              blk_done,
  output logic              txn_done,
  output logic              list_done,
  output logic              cfg_err,
  output logic              irq
);
  localparam int unsigned NL = NUM_LEVELS;

  logic              rst_n_s;
  logic              busy_q, busy_d;
  req_mode_e         mode_q, mode_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  lim_q [NL];
  logic [LEN_W-1:0]  lim_cfg [NL];
  logic [NL-1:0]     step, last;
  logic              cfg_ok, start_go, fire, grant, unit_end, txn_end;

  hxs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign lim_cfg[0] = cfg_frag_len;
  assign lim_cfg[1] = cfg_frags_per_blk;
  assign lim_cfg[2] = cfg_blks_per_txn;

  assign cfg_ok   = (|cfg_frag_len) && (|cfg_frags_per_blk) && (|cfg_blks_per_txn);
  assign start_go = start && !busy_q && cfg_ok;
  assign cfg_err  = start && !busy_q && !cfg_ok;

  assign beat_valid = busy_q && grant;
  assign fire       = beat_valid && beat_ready;

  // Chained counters: each level steps when the level below wraps.
  for (genvar g = 0; g < NL; g++) begin : g_lvl
    if (g == 0) begin : g_base
      assign step[g] = fire;
    end else begin : g_up
      assign step[g] = step[g-1] && last[g-1];
    end

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s)      lim_q[g] <= '0;
      else if (start_go) lim_q[g] <= lim_cfg[g];
    end

    hxs_level_cnt #(.W(LEN_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n_s),
      .load  (start_go),
      .step  (step[g]),
      .limit (lim_q[g]),
      .last  (last[g])
    );
  end

  assign frag_done = step[1];
  assign blk_done  = step[2];
  assign txn_end   = step[2] && last[2];
  assign txn_done  = txn_end;
  assign list_done = txn_end && (mode_q == RM_LIST) && last_node;

  always_comb begin
    case (mode_q)
      RM_FRAG:  unit_end = step[1];
      RM_BLOCK: unit_end = step[2];
      default:  unit_end = txn_end;
    endcase
  end

  hxs_auth u_auth (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .active   (busy_q),
    .req      (req),
    .unit_end (unit_end),
    .txn_end  (txn_end),
    .grant    (grant)
  );

  always_comb begin
    busy_d = busy_q;
    mode_d = mode_q;
    addr_d = addr_q;
    if (start_go) begin
      busy_d = 1'b1;
      mode_d = req_mode_e'(cfg_req_mode);
      addr_d = cfg_base_addr;
    end else begin
      if (txn_end) busy_d = 1'b0;
      if (fire)    addr_d = addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0;
      mode_q <= RM_FRAG;
      addr_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (start_go) mode_q <= mode_d;
      if (start_go || fire) addr_q <= addr_d;
    end
  end

  hxs_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .sel     (cfg_irq_sel),
    .frag_ev (frag_done),
    .blk_ev  (blk_done),
    .txn_ev  (txn_done),
    .list_ev (list_done),
    .cerr_ev (cfg_err),
    .clr     (irq_clr),
    .irq     (irq)
  );

  assign busy      = busy_q;
  assign beat_addr = addr_q;
endmodule

// File: rtl/hxs_chk.sv
module hxs_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cfg_irq_sel,
  input logic              last_node,
  input logic              beat_ready,
  input logic              irq_clr,
  input logic              beat_valid,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              busy,
  input logic              frag_done,
  input logic              blk_done,
  input logic              txn_done,
  input logic              list_done,
  input logic              cfg_err,
  input logic              irq
);
  assert_valid_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> busy);

  assert_reject_stays_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !busy);

  assert_frag_on_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frag_done |-> (beat_valid && beat_ready));

  assert_blk_nests_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> frag_done);

  assert_txn_nests_R5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |-> blk_done);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr)));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !txn_done) |=> (beat_addr == $past(beat_addr) + ADDR_W'(1)));

  assert_list_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |-> (txn_done && last_node));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !frag_done && !blk_done && !txn_done && !list_done && !cfg_err) |=> !irq);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && cfg_irq_sel == 4'd4) |=> irq);

  assert_end_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |=> (!busy && !beat_valid));
endmodule

bind hxfer_seq hxs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_irq_sel (cfg_irq_sel),
  .last_node   (last_node),
  .beat_ready  (beat_ready),
  .irq_clr     (irq_clr),
  .beat_valid  (beat_valid),
  .beat_addr   (beat_addr),
  .busy        (busy),
  .frag_done   (frag_done),
  .blk_done    (blk_done),
  .txn_done    (txn_done),
  .list_done   (list_done),
  .cfg_err     (cfg_err),
  .irq         (irq)
);

// File: tb/hxfer_seq_tb_top.sv
module hxfer_seq_tb_top;
  localparam int LW = 16;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, start, req, last_node, beat_ready, irq_clr;
  logic [LW-1:0] fl, fpb, bpt;
  logic [1:0]    mode;
  logic [3:0]    isel;
  logic [AW-1:0] base;
  logic          beat_valid, busy, frag_done, blk_done, txn_done, list_done, cfg_err, irq;
  logic [AW-1:0] beat_addr;

  hxfer_seq #(.LEN_W(LW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_frag_len(fl), .cfg_frags_per_blk(fpb),
    .cfg_blks_per_txn(bpt), .cfg_req_mode(mode), .cfg_irq_sel(isel),
    .cfg_base_addr(base), .start(start), .req(req), .last_node(last_node),
    .beat_ready(beat_ready), .irq_clr(irq_clr), .beat_valid(beat_valid),
    .beat_addr(beat_addr), .busy(busy), .frag_done(frag_done), .blk_done(blk_done),
    .txn_done(txn_done), .list_done(list_done), .cfg_err(cfg_err), .irq(irq)
  );

  typedef struct packed { logic [4:0] ev; logic [AW-1:0] addr; } item_t;
  item_t expq[$];

  int  errs = 0, checks = 0, fires = 0, tgt = 0, wd = 0;
  bit  done = 0;
  int  rdy_mode = 0;  // 0 always ready, 1 toggling, 2 stalled
  bit  tog = 0;
  always @(posedge clk) tog <= ~tog;
  assign beat_ready = (rdy_mode == 0) || (rdy_mode == 1 && tog);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Driver: arms the channel and pushes the expected event stream.
  task automatic do_start(input int l0, input int l1, input int l2, input int m,
                          input int b, input bit ln);
    fl = LW'(l0); fpb = LW'(l1); bpt = LW'(l2); mode = 2'(m);
    base = AW'(b); last_node = ln;
    if (l0 == 0 || l1 == 0 || l2 == 0) begin
      expq.push_back('{ev: 5'b00001, addr: '0});
    end else begin
      for (int k = 0; k < l2; k++) begin
        for (int f = 0; f < l1; f++) begin
          item_t it;
          bit eb, et;
          eb = (f == l1 - 1);
          et = eb && (k == l2 - 1);
          it.ev   = {et && (m == 3) && ln, et, eb, 1'b1, 1'b0};
          it.addr = AW'(b + ((k * l1) + f + 1) * l0 - 1);
          expq.push_back(it);
        end
      end
    end
    start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  task automatic pulse_req();
    req = 1'b1;
    tick(1);
    req = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1;
    tick(1);
    irq_clr = 1'b0;
  endtask

  task automatic wait_fires(input int n);
    tgt += n;
    while (fires < tgt) tick(1);
    tick(4);
  endtask

  // Monitor: counts accepted beats and compares events against the queue.
  logic [4:0] ev_now;
  item_t      ev_exp;
  always @(negedge clk) begin
    if (rst_n) begin
      if (beat_valid && beat_ready) fires++;
      ev_now = {list_done, txn_done, blk_done, frag_done, cfg_err};
      if (ev_now != 5'b0) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R5 unexpected event", ev_now, 0);
        end else begin
          ev_exp = expq.pop_front();
          chk(ev_now == ev_exp.ev, "R5/R8 event kind", ev_now, ev_exp.ev);
          if (!ev_exp.ev[0])
            chk(beat_addr == ev_exp.addr, "R6 last beat address", beat_addr, ev_exp.addr);
        end
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; req = 1'b0; last_node = 1'b0; irq_clr = 1'b0;
    fl = '0; fpb = '0; bpt = '0; mode = '0; isel = '0; base = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    chk(!beat_valid, "R1 beat_valid after reset", beat_valid, 0);
    chk(!busy, "R1 busy after reset", busy, 0);
    chk(!irq, "R1 irq after reset", irq, 0);

    pulse_req();
    tick(5);
    chk(fires == 0, "R2 req while idle ignored", fires, 0);

    isel = 4'd8;
    do_start(2, 0, 2, 0, 'h40, 0);
    tick(2);
    chk(!busy, "R3 zero length rejected", busy, 0);
    chk(irq, "R9 cfg-error selector sets irq", irq, 1);
    clear_irq();
    chk(!irq, "R10 clear drops irq", irq, 0);

    isel = 4'd1;
    do_start(2, 3, 2, 0, 'h100, 0);
    chk(busy, "R2 busy after start", busy, 1);
    chk(beat_addr == 'h100, "R2 base address loaded", beat_addr, 'h100);
    pulse_req();
    wait_fires(2);
    chk(fires == 2, "R4 fragment mode runs one fragment", fires, 2);
    chk(!beat_valid, "R4 fragment mode stops", beat_valid, 0);
    chk(irq, "R9 fragment selector", irq, 1);
    clear_irq();

    rdy_mode = 2;
    pulse_req(); pulse_req(); pulse_req();
    rdy_mode = 0;
    wait_fires(4);
    tick(4);
    chk(fires == 6, "R7 one pending request kept", fires, 6);
    chk(busy, "R7 still busy", busy, 1);
    for (int i = 0; i < 3; i++) begin
      pulse_req();
      wait_fires(2);
    end
    chk(!busy, "R11 busy drops at transaction end", busy, 0);
    clear_irq();

    isel = 4'd6;
    do_start(2, 3, 2, 1, 'h200, 0);
    rdy_mode = 1;
    pulse_req();
    wait_fires(6);
    tick(4);
    chk(fires == 18, "R4 block mode runs one block", fires, 18);
    chk(irq, "R9 transaction-or-block selector", irq, 1);
    clear_irq();
    chk(!irq, "R10 clear", irq, 0);
    pulse_req();
    wait_fires(6);
    chk(!busy, "R4 block mode finishes", busy, 0);
    rdy_mode = 0;
    clear_irq();

    isel = 4'd4;
    do_start(3, 2, 2, 2, 'h300, 0);
    pulse_req();
    tick(2);
    pulse_req();
    wait_fires(12);
    chk(fires == 36, "R4 transaction mode runs all", fires, 36);
    chk(!busy, "R11 idle after transaction", busy, 0);
    chk(irq, "R9 transaction selector", irq, 1);
    clear_irq();

    isel = 4'd7;
    do_start(1, 2, 2, 3, 'h400, 0);
    tick(2);
    chk(!beat_valid, "R11 pending discarded at end", beat_valid, 0);
    pulse_req();
    wait_fires(4);
    chk(!irq, "R8 no list irq without last node", irq, 0);
    do_start(1, 2, 2, 3, 'h480, 1);
    pulse_req();
    wait_fires(4);
    chk(irq, "R8 list irq on last node", irq, 1);
    clear_irq();

    isel = 4'd5;
    do_start(2, 2, 1, 0, 'h500, 0);
    pulse_req();
    tick(1);
    irq_clr = 1'b1;
    tick(1);
    irq_clr = 1'b0;
    chk(irq, "R10 set wins over clear", irq, 1);
    wait_fires(2);
    clear_irq();
    pulse_req();
    wait_fires(2);
    chk(irq, "R9 transaction-or-fragment selector", irq, 1);
    chk(!busy, "R11 idle", busy, 0);
    clear_irq();

    isel = 4'd0;
    do_start(1, 1, 1, 2, 'h600, 0);
    pulse_req();
    wait_fires(1);
    chk(!irq, "R9 selector none", irq, 0);
    chk(expq.size() == 0, "R5 all events seen", expq.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule